// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector and Router

This block watches a set of general-purpose input pins, decides per pin whether a configured trigger condition has occurred, and records the event in status registers that software can read and acknowledge. Each pin carries a three-bit trigger code (off, rising edge, falling edge, either edge, low level, high level) and four routing enables that pick which of four destinations see the event: processor A maskable, processor A non-maskable, processor B maskable and processor B non-maskable.

A trigger always marks the pin in a global pending register. It also marks the pin in each destination register whose routing enable is on. Two combined outputs leave the block. The maskable line is high while either maskable destination register holds a pending bit. The non-maskable line does the same for the two non-maskable destination registers. Pins are grouped in 32-bit banks. A write-one-to-clear alias on a bank acknowledges the chosen pins in the global register and in all four destination registers together. Pin inputs pass through a synchronizer before detection. The edge detector's history register is seeded from the first synchronized sample, so no edge appears just because reset ended.

Top module: `gpio_irq_router`

## Requirements
- R1: Trigger code 1 fires on a 0-to-1 change of the synchronized pin, code 2 on a 1-to-0 change, and code 3 on either change. An edge type never fires while the pin holds steady.
- R2: Code 4 fires on every cycle the synchronized pin is 0, and code 5 on every cycle it is 1. An acknowledge issued while the level still holds is followed at once by the bit being set again.
- R3: Codes 0, 6 and 7 never fire, whatever the pin does and whatever routing is enabled.
- R4: When a pin fires, its global pending bit is set even if all four of its routing enables are off.
- R5: Routing enable bit 0 selects processor A maskable, bit 1 selects processor A non-maskable, bit 2 selects processor B maskable and bit 3 selects processor B non-maskable. A firing pin sets its bit only in the destination registers whose enable is 1.
- R6: `irq_o` is 1 exactly while any bit of either maskable destination register, in either bank, is pending. `nmi_o` behaves the same way for the two non-maskable destination registers.
- R7: A write to 0x04C (bank 0) or 0x058 (bank 1) clears the written-1 bits of that bank in the global register and in all four destination registers. The other bank is untouched.
- R8: A direct write to 0x044 or 0x050 replaces that bank's global pending bits, and a write to the set alias 0x048 or 0x054 ORs bits into them. Neither write changes a destination register or either output line.
- R9: If an acknowledge and a new trigger fall on the same bit in the same cycle, the bit ends up set in the global register and in every routed destination register.
- R10: After reset, a pin that is already high with a rising-edge trigger does not fire, and no pin is evaluated until its history holds a real synchronized sample.
- R11: A pin change driven before clock edge n is recorded in status at edge n+2 and becomes readable after that edge. Nothing is recorded earlier.
- R12: The read map is as follows. Global pending is at 0x044 (pins 0-31) and 0x050 (pins 32-39). The destination registers for pins 0-31 are at 0x060, 0x064, 0x068 and 0x06C. The destination registers for pins 32-39 are at 0x074, 0x078, 0x07C and 0x080. In both banks the four destinations appear in the order of the R5 routing bits. All of these registers read 0 after reset, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous pin levels |
| cfg_trig_i | input | 3*NUM_PINS | Trigger code of pin i at bits [3i+2:3i] |
| cfg_route_i | input | 4*NUM_PINS | Routing enables of pin i at bits [4i+3:4i] |
| bus_addr_i | input | 12 | Register byte address |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Combined maskable interrupt line |
| nmi_o | output | 1 | Combined non-maskable interrupt line |

## Verification
Two functions can land on the same clock edge: a software acknowledge of a pending bit and a fresh trigger on that same bit. The bench provokes the collision in two ways. It places a clear write exactly two edges after a rising pin change, and it clears a high-level pin while the level is still held. The collision is judged by reading back the global and routed destination bits and the output line after the edge; all of them must still be set. A behavioural reference model then runs a long pseudo-random stretch in which clears, set-alias writes and pin toggles overlap freely, and its results are compared every cycle.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int REG_AW   = 12;
  localparam int DEST_CNT = 4;
  localparam int BANK_W   = 32;

  // destination order, also the routing-enable bit order
  localparam int DST_A_INT = 0;
  localparam int DST_A_NMI = 1;
  localparam int DST_B_INT = 2;
  localparam int DST_B_NMI = 3;

  localparam logic [2:0] TRIG_RISE = 3'd1;
  localparam logic [2:0] TRIG_FALL = 3'd2;
  localparam logic [2:0] TRIG_BOTH = 3'd3;
  localparam logic [2:0] TRIG_LOW  = 3'd4;
  localparam logic [2:0] TRIG_HIGH = 3'd5;

  // kind: 0 direct, 1 set alias, 2 clear alias
  function automatic logic [REG_AW-1:0] stat_ofs(int bank, int kind);
    return (bank == 0) ? (12'h044 + 12'(4 * kind)) : (12'h050 + 12'(4 * kind));
  endfunction

  function automatic logic [REG_AW-1:0] dest_ofs(int bank, int dst);
    return (bank == 0) ? (12'h060 + 12'(4 * dst)) : (12'h074 + 12'(4 * dst));
  endfunction

  function automatic logic trig_hit(logic [2:0] code, logic was, logic now);
    logic r;
    case (code)
      TRIG_RISE: r = !was && now;
      TRIG_FALL: r = was && !now;
      TRIG_BOTH: r = was ^ now;
      TRIG_LOW:  r = !now;
      TRIG_HIGH: r = now;
      default:   r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
  parameter int W      = 40,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] prev_o,
  output logic         det_en_o
);
  localparam int CW = $clog2(STAGES + 1);

  logic [W-1:0]  chain [STAGES];
  logic [W-1:0]  prev_q;
  logic [CW-1:0] fill_q;
  logic          sync_valid;
  logic          primed_q;

  assign sync_valid = (fill_q == CW'(STAGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= pin_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q   <= '0;
      primed_q <= 1'b0;
      prev_q   <= '0;
    end else begin
      if (!sync_valid) fill_q <= fill_q + 1'b1;
      primed_q <= sync_valid;
      prev_q   <= chain[STAGES-1];
    end
  end

  assign lvl_o    = chain[STAGES-1];
  assign prev_o   = prev_q;
  assign det_en_o = primed_q;

  // R10
  primed_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(primed_q) |-> $past(sync_valid));
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int W = 40
) (
  input  logic [3*W-1:0]                  cfg_trig_i,
  input  logic [4*W-1:0]                  cfg_route_i,
  input  logic [W-1:0]                    lvl_i,
  input  logic [W-1:0]                    prev_i,
  input  logic                            en_i,
  output logic [W-1:0]                    hit_o,
  output logic [DEST_CNT-1:0][W-1:0]      hit_dst_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign hit_o[i] = en_i && trig_hit(cfg_trig_i[3*i +: 3], prev_i[i], lvl_i[i]);
    for (genvar d = 0; d < DEST_CNT; d++) begin : g_dst
      assign hit_dst_o[d][i] = hit_o[i] && cfg_route_i[4*i + d];
    end
  end
endmodule

// File: rtl/gpio_irq_status.sv
`timescale 1ns/1ps
module gpio_irq_status
  import gpio_irq_pkg::*;
#(
  parameter int W = 40
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [W-1:0]                hit_i,
  input  logic [DEST_CNT-1:0][W-1:0]  hit_dst_i,
  input  logic [W-1:0]                wr_dir_i,
  input  logic [W-1:0]                wr_dat_i,
  input  logic [W-1:0]                wr_set_i,
  input  logic [W-1:0]                wr_clr_i,
  output logic [W-1:0]                glob_o,
  output logic [DEST_CNT-1:0][W-1:0]  dst_o
);
  logic [W-1:0]               glob_q, glob_n;
  logic [DEST_CNT-1:0][W-1:0] dst_q;

  always_comb begin
    glob_n = (glob_q & ~wr_dir_i) | (wr_dat_i & wr_dir_i);
    glob_n = glob_n | wr_set_i;
    glob_n = glob_n & ~wr_clr_i;
    glob_n = glob_n | hit_i;          // a new trigger beats the acknowledge
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) glob_q <= '0;
    else        glob_q <= glob_n;
  end

  for (genvar d = 0; d < DEST_CNT; d++) begin : g_dst
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dst_q[d] <= '0;
      else        dst_q[d] <= (dst_q[d] & ~wr_clr_i) | hit_dst_i[d];
    end

    // R5
    dst_set_by_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((dst_q[d] & ~$past(dst_q[d])) & ~$past(hit_dst_i[d])) == '0);

    // R9
    dst_hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_dst_i[d] != '0) |=> ((dst_q[d] & $past(hit_dst_i[d])) == $past(hit_dst_i[d])));
  end

  assign glob_o = glob_q;
  assign dst_o  = dst_q;

  // R4
  glob_set_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i != '0) |=> ((glob_q & $past(hit_i)) == $past(hit_i)));

  // R7
  clr_all_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_clr_i & ~hit_i) != '0) |=>
      (((glob_q | dst_q[0] | dst_q[1] | dst_q[2] | dst_q[3]) & $past(wr_clr_i & ~hit_i)) == '0));
endmodule

// File: rtl/gpio_irq_router.sv
`timescale 1ns/1ps
module gpio_irq_router
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS    = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_i,
  input  logic [3*NUM_PINS-1:0] cfg_trig_i,
  input  logic [4*NUM_PINS-1:0] cfg_route_i,
  input  logic [REG_AW-1:0]     bus_addr_i,
  input  logic                  bus_we_i,
  input  logic [31:0]           bus_wdata_i,
  output logic [31:0]           bus_rdata_o,
  output logic                  irq_o,
  output logic                  nmi_o
);
  localparam int NUM_BANKS = (NUM_PINS + BANK_W - 1) / BANK_W;

  logic [NUM_PINS-1:0]               lvl, prev_lvl, hit;
  logic [DEST_CNT-1:0][NUM_PINS-1:0] hit_dst, dst;
  logic [NUM_PINS-1:0]               glob;
  logic                              det_en;
  logic [NUM_BANKS-1:0]              we_dir, we_set, we_clr;
  logic [NUM_PINS-1:0]               dir_m, dat_m, set_m, clr_m;

  gpio_irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .lvl_o(lvl), .prev_o(prev_lvl), .det_en_o(det_en)
  );

  gpio_irq_detect #(.W(NUM_PINS)) u_detect (
    .cfg_trig_i(cfg_trig_i), .cfg_route_i(cfg_route_i),
    .lvl_i(lvl), .prev_i(prev_lvl), .en_i(det_en),
    .hit_o(hit), .hit_dst_o(hit_dst)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign we_dir[b] = bus_we_i && (bus_addr_i == stat_ofs(b, 0));
    assign we_set[b] = bus_we_i && (bus_addr_i == stat_ofs(b, 1));
    assign we_clr[b] = bus_we_i && (bus_addr_i == stat_ofs(b, 2));
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_wmask
    assign dat_m[i] = bus_wdata_i[i % BANK_W];
    assign dir_m[i] = we_dir[i / BANK_W];
    assign set_m[i] = we_set[i / BANK_W] && bus_wdata_i[i % BANK_W];
    assign clr_m[i] = we_clr[i / BANK_W] && bus_wdata_i[i % BANK_W];
  end

  gpio_irq_status #(.W(NUM_PINS)) u_status (
    .clk(clk), .rst_n(rst_n), .hit_i(hit), .hit_dst_i(hit_dst),
    .wr_dir_i(dir_m), .wr_dat_i(dat_m), .wr_set_i(set_m), .wr_clr_i(clr_m),
    .glob_o(glob), .dst_o(dst)
  );

  always_comb begin
    bus_rdata_o = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (bus_addr_i == stat_ofs(i / BANK_W, 0)) bus_rdata_o[i % BANK_W] = glob[i];
      for (int d = 0; d < DEST_CNT; d++) begin
        if (bus_addr_i == dest_ofs(i / BANK_W, d)) bus_rdata_o[i % BANK_W] = dst[d][i];
      end
    end
  end

  assign irq_o = |(dst[DST_A_INT] | dst[DST_B_INT]);
  assign nmi_o = |(dst[DST_A_NMI] | dst[DST_B_NMI]);

  // R6
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(hit_dst[DST_A_INT] | hit_dst[DST_B_INT])));

  // R6
  nmi_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> $past(|(hit_dst[DST_A_NMI] | hit_dst[DST_B_NMI])));

  // R7
  line_drop_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(irq_o) || $fell(nmi_o)) |-> $past(|we_clr));

  // R10
  quiet_until_primed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |-> (hit == '0));
endmodule

// File: tb/gpio_irq_router_bench.sv
`timescale 1ns/1ps
module gpio_irq_router_bench;
  localparam int NP = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pin = '0;
  logic [2:0]    trig  [NP];
  logic [3:0]    route [NP];
  logic [3*NP-1:0] cfg_trig;
  logic [4*NP-1:0] cfg_route;
  logic [11:0]   bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          irq, nmi;

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R6";

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      cfg_trig[3*i +: 3]  = trig[i];
      cfg_route[4*i +: 4] = route[i];
    end
  end

  gpio_irq_router #(.NUM_PINS(NP), .SYNC_STAGES(2)) u_gpio_irq_router (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .cfg_trig_i(cfg_trig), .cfg_route_i(cfg_route),
    .bus_addr_i(bus_addr), .bus_we_i(bus_we), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq), .nmi_o(nmi)
  );

  // behavioural reference
  logic [NP-1:0] hist [$];
  logic [NP-1:0] m_glob;
  logic [NP-1:0] m_dst [4];

  task automatic model_reset();
    hist.delete();
    m_glob = '0;
    for (int d = 0; d < 4; d++) m_dst[d] = '0;
  endtask

  task automatic model_edge();
    logic [NP-1:0] fired, cur, old, ack;
    fired = '0;
    ack = '0;
    hist.push_back(pin);
    if (hist.size() > 4) hist.delete(0);
    if (hist.size() == 4) begin
      cur = hist[1];
      old = hist[0];
      for (int p = 0; p < NP; p++) begin
        if (trig[p] == 3'd1) fired[p] = cur[p] & ~old[p];
        else if (trig[p] == 3'd2) fired[p] = old[p] & ~cur[p];
        else if (trig[p] == 3'd3) fired[p] = cur[p] != old[p];
        else if (trig[p] == 3'd4) fired[p] = (cur[p] == 1'b0);
        else if (trig[p] == 3'd5) fired[p] = (cur[p] == 1'b1);
      end
    end
    if (bus_we) begin
      case (bus_addr)
        12'h044: m_glob[31:0]  = bus_wdata;
        12'h048: m_glob[31:0]  = m_glob[31:0] | bus_wdata;
        12'h04C: ack[31:0]     = bus_wdata;
        12'h050: m_glob[39:32] = bus_wdata[7:0];
        12'h054: m_glob[39:32] = m_glob[39:32] | bus_wdata[7:0];
        12'h058: ack[39:32]    = bus_wdata[7:0];
        default: ;
      endcase
    end
    m_glob = (m_glob & ~ack) | fired;
    for (int d = 0; d < 4; d++)
      for (int p = 0; p < NP; p++)
        if (ack[p]) m_dst[d][p] = 1'b0;
    for (int p = 0; p < NP; p++)
      for (int d = 0; d < 4; d++)
        if (fired[p] && route[p][d]) m_dst[d][p] = 1'b1;
  endtask

  function automatic logic [31:0] model_read(logic [11:0] a);
    case (a)
      12'h044: return m_glob[31:0];
      12'h050: return {24'h0, m_glob[39:32]};
      12'h060: return m_dst[0][31:0];
      12'h064: return m_dst[1][31:0];
      12'h068: return m_dst[2][31:0];
      12'h06C: return m_dst[3][31:0];
      12'h074: return {24'h0, m_dst[0][39:32]};
      12'h078: return {24'h0, m_dst[1][39:32]};
      12'h07C: return {24'h0, m_dst[2][39:32]};
      12'h080: return {24'h0, m_dst[3][39:32]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one clock: model follows the inputs the design samples, then compare lines
  task automatic step();
    model_edge();
    @(posedge clk);
    @(negedge clk);
    chk(cur_req, "irq_o", {31'h0, irq}, {31'h0, |(m_dst[0] | m_dst[2])});
    chk(cur_req, "nmi_o", {31'h0, nmi}, {31'h0, |(m_dst[1] | m_dst[3])});
  endtask

  task automatic steps(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] v);
    bus_addr = a;
    bus_wdata = v;
    bus_we = 1'b1;
    step();
    bus_we = 1'b0;
  endtask

  task automatic rd(string req, logic [11:0] a);
    bus_addr = a;
    #0.1;
    chk(req, $sformatf("model read %h", a), bus_rdata, model_read(a));
  endtask

  task automatic rdl(string req, logic [11:0] a, logic [31:0] exp);
    bus_addr = a;
    #0.1;
    chk(req, $sformatf("read %h", a), bus_rdata, exp);
  endtask

  task automatic rd_all(string req);
    rd(req, 12'h044); rd(req, 12'h050);
    rd(req, 12'h060); rd(req, 12'h064); rd(req, 12'h068); rd(req, 12'h06C);
    rd(req, 12'h074); rd(req, 12'h078); rd(req, 12'h07C); rd(req, 12'h080);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    for (int i = 0; i < NP; i++) begin trig[i] = 3'd0; route[i] = 4'h0; end
    // R10: pin already high with rising trigger while in reset
    pin[3] = 1'b1; trig[3] = 3'd1; route[3] = 4'h1;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset values and unmapped address
    rdl("R12", 12'h044, 0); rdl("R12", 12'h050, 0); rdl("R12", 12'h060, 0);
    rdl("R12", 12'h064, 0); rdl("R12", 12'h068, 0); rdl("R12", 12'h06C, 0);
    rdl("R12", 12'h074, 0); rdl("R12", 12'h080, 0); rdl("R12", 12'h0FC, 0);
    chk("R12", "irq_o after reset", {31'h0, irq}, 0);
    cur_req = "R10";
    steps(8);
    rdl("R10", 12'h044, 0);

    // R1 rising with R11 latency, routed to A maskable
    cur_req = "R11";
    trig[0] = 3'd1; route[0] = 4'h1;
    pin[0] = 1'b1;
    steps(2);
    rdl("R11", 12'h044, 0);
    step();
    rdl("R11", 12'h044, 32'h1);
    rdl("R5", 12'h060, 32'h1);
    rdl("R5", 12'h064, 32'h0);
    chk("R6", "irq_o set", {31'h0, irq}, 1);
    cur_req = "R7";
    wr(12'h04C, 32'h1);
    rdl("R7", 12'h044, 0); rdl("R7", 12'h060, 0);
    chk("R7", "irq_o dropped", {31'h0, irq}, 0);
    cur_req = "R1";
    pin[0] = 1'b0;
    steps(5);
    rdl("R1", 12'h044, 0);

    // R1 falling routed to B non-maskable
    trig[1] = 3'd2; route[1] = 4'h8;
    pin[1] = 1'b1;
    steps(5);
    rdl("R1", 12'h044, 0);
    pin[1] = 1'b0;
    steps(4);
    rdl("R1", 12'h044, 32'h2);
    rdl("R5", 12'h06C, 32'h2);
    chk("R6", "nmi_o set", {31'h0, nmi}, 1);
    chk("R6", "irq_o quiet", {31'h0, irq}, 0);
    wr(12'h04C, 32'h2);
    chk("R7", "nmi_o dropped", {31'h0, nmi}, 0);

    // R1 either edge, R4 no routing
    cur_req = "R4";
    trig[2] = 3'd3;
    pin[2] = 1'b1;
    steps(4);
    rdl("R4", 12'h044, 32'h4);
    rdl("R4", 12'h060, 0);
    chk("R4", "irq_o no route", {31'h0, irq}, 0);
    wr(12'h04C, 32'h4);
    pin[2] = 1'b0;
    steps(4);
    rdl("R1", 12'h044, 32'h4);
    wr(12'h04C, 32'h4);

    // R3 disabled codes
    cur_req = "R3";
    trig[4] = 3'd0; trig[5] = 3'd6; trig[6] = 3'd7;
    route[4] = 4'hF; route[5] = 4'hF; route[6] = 4'hF;
    pin[6:4] = 3'b111;
    steps(4);
    pin[6:4] = 3'b000;
    steps(4);
    rdl("R3", 12'h044, 0);
    chk("R3", "irq_o", {31'h0, irq}, 0);

    // bank 0 pending, then bank 1 high-level pin: R2 R5 R7
    cur_req = "R2";
    pin[0] = 1'b1;
    steps(4);
    trig[33] = 3'd5; route[33] = 4'h6;
    pin[33] = 1'b1;
    steps(4);
    rdl("R5", 12'h050, 32'h2); rdl("R5", 12'h078, 32'h2); rdl("R5", 12'h07C, 32'h2);
    rdl("R5", 12'h074, 0); rdl("R5", 12'h080, 0);
    chk("R6", "nmi_o bank1", {31'h0, nmi}, 1);
    wr(12'h058, 32'h2);
    rdl("R2", 12'h050, 32'h2);
    rdl("R7", 12'h044, 32'h1);
    rdl("R7", 12'h060, 32'h1);
    pin[33] = 1'b0;
    steps(4);
    wr(12'h058, 32'h2);
    rdl("R7", 12'h050, 0); rdl("R7", 12'h078, 0); rdl("R7", 12'h07C, 0);
    chk("R6", "nmi_o after bank1 ack", {31'h0, nmi}, 0);
    chk("R6", "irq_o held by bank0", {31'h0, irq}, 1);
    wr(12'h04C, 32'h1);
    chk("R6", "irq_o all clear", {31'h0, irq}, 0);

    // R8 direct and set-alias writes
    cur_req = "R8";
    wr(12'h044, 32'h0000F000);
    rdl("R8", 12'h044, 32'h0000F000);
    rdl("R8", 12'h060, 0);
    chk("R8", "irq_o", {31'h0, irq}, 0);
    wr(12'h054, 32'h80);
    rdl("R8", 12'h050, 32'h80);
    rdl("R8", 12'h080, 0);
    chk("R8", "nmi_o", {31'h0, nmi}, 0);
    wr(12'h04C, 32'hFFFFFFFF);
    wr(12'h058, 32'hFF);
    rdl("R8", 12'h044, 0); rdl("R8", 12'h050, 0);

    // R9 acknowledge on the same edge as a new trigger
    cur_req = "R9";
    trig[7] = 3'd1; route[7] = 4'h1;
    pin[7] = 1'b1;
    steps(2);
    wr(12'h04C, 32'h80);
    rdl("R9", 12'h044, 32'h80);
    rdl("R9", 12'h060, 32'h80);
    chk("R9", "irq_o", {31'h0, irq}, 1);
    wr(12'h04C, 32'h80);
    rdl("R9", 12'h044, 0);

    // pseudo-random overlap of all functions against the model
    cur_req = "R6";
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < NP; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      trig[i]  = lfsr[2:0];
      route[i] = lfsr[7:4];
    end
    for (int t = 0; t < 600; t++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (lfsr[3:0] == 4'h0) pin = pin ^ {lfsr[7:0], lfsr};
      if (lfsr[9:6] == 4'h5) wr(lfsr[10] ? 12'h058 : 12'h04C, {lfsr[15:0], lfsr[31:16]});
      else if (lfsr[9:6] == 4'h9) wr(12'h048, 32'h1 << lfsr[14:10]);
      else step();
      if (t % 8 == 0) rd_all("R7");
    end
    rd_all("R12");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule